// File: doc/BRIEF.md
# Accumulator Processor Datapath

This block is the register-transfer datapath of a small 16-bit accumulator machine. It holds four registers: the accumulator, a byte-addressed program counter, an address-out register that drives the external address bus, and a data-in register that captures words read from memory. The data-in register feeds an internal A-bus. The A-bus is the A operand of a small ALU, and the accumulator is its B operand.

A separate control sequencer drives the block each cycle through a set of control points. These are the ALU operation, the latch enables, the program-counter source, the address-out source, the data-bus drive enable and the memory command. The sequencer gets back the opcode field of the captured word and the accumulator sign bit, and it uses them to branch. The program counter always steps by two. It can take the A-bus value and add two in the same edge, so a jump leaves the target in the address register and the target plus two in the program counter.

Top module: `acc_datapath`

## Requirements
- R1: While `rst_n` is low, the accumulator, program counter, address-out and data-in registers are all cleared to zero. After release, `addr_bus`, `wr_data`, `opcode` and `ac_sign` all read zero.
- R2: On a rising edge with `di_le` high, the data-in register captures `rd_data`. `opcode` always shows data-in bits 14:10 (bit 15 is the indirect flag and bits 9:0 are the address field). With `di_le` low the register holds its value.
- R3: On a rising edge with `ac_le` high, the accumulator loads the ALU result. `alu_op` selects the result: 000 gives DI, 001 gives the bitwise inverse of AC, 010 gives DI AND AC, 011 gives DI + AC modulo 2^16, and 100 gives AC shifted right by one with a zero fill.
- R4: The unused ALU codes 101, 110 and 111 produce zero. With `ac_le` low, the accumulator holds its value whatever `alu_op` is.
- R5: On a rising edge with `pc_le` high, the program counter becomes PC+2 when `pc_from_bus` is 0 and DI+2 when it is 1, both modulo 2^16. With `pc_le` low it holds.
- R6: On a rising edge with `ao_le` high, the address-out register loads the program counter value from before that edge when `ao_from_bus` is 0, and DI when it is 1. It drives `addr_bus` and holds while `ao_le` is low.
- R7: `wr_data` always carries the accumulator. `wr_en` equals `dbus_sel`. `mem_cmd` passes `mem_op` through unchanged (00 idle, 01 read, 10 write).
- R8: `ac_sign` equals accumulator bit 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alu_op | input | 3 | ALU operation select |
| di_le | input | 1 | Data-in latch enable |
| ac_le | input | 1 | Accumulator latch enable |
| pc_le | input | 1 | Program counter latch enable |
| pc_from_bus | input | 1 | PC base: 0 = PC, 1 = A-bus (both plus 2) |
| ao_le | input | 1 | Address-out latch enable |
| ao_from_bus | input | 1 | Address-out source: 0 = PC, 1 = A-bus |
| dbus_sel | input | 1 | Drive the accumulator onto the data bus |
| mem_op | input | 2 | Memory command from the sequencer |
| rd_data | input | 16 | Data bus value read from memory |
| addr_bus | output | 16 | External address bus |
| wr_data | output | 16 | Data bus value written to memory |
| wr_en | output | 1 | Data bus drive enable |
| mem_cmd | output | 2 | Memory command to memory |
| opcode | output | 5 | Opcode field of the data-in register |
| ac_sign | output | 1 | Accumulator sign bit |

## Verification
The bench builds the block with its default 16-bit width and a program-counter step of two. At that width, random data-bus words and random control words reach the carry-out of the adder, the sign bit and the program-counter wrap near 0xFFFE within a few hundred cycles. Directed sequences add a jump (load PC and add two with AO taking the target), each ALU code including the three unused ones, and enables held low while other inputs move.

// File: rtl/acc_datapath.sv
module acc_datapath #(
  parameter int W       = 16,
  parameter int OPC_W   = 5,
  parameter int PC_STEP = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       alu_op,
  input  logic             di_le,
  input  logic             ac_le,
  input  logic             pc_le,
  input  logic             pc_from_bus,
  input  logic             ao_le,
  input  logic             ao_from_bus,
  input  logic             dbus_sel,
  input  logic [1:0]       mem_op,
  input  logic [W-1:0]     rd_data,
  output logic [W-1:0]     addr_bus,
  output logic [W-1:0]     wr_data,
  output logic             wr_en,
  output logic [1:0]       mem_cmd,
  output logic [OPC_W-1:0] opcode,
  output logic             ac_sign
);
  localparam int OPC_HI = W - 2;
  localparam int OPC_LO = OPC_HI - OPC_W + 1;
  localparam logic [W-1:0] STEP = W'(PC_STEP);

  logic [W-1:0] ac_q, pc_q, ao_q, di_q;
  logic [W-1:0] abus, alu_y, pc_nxt, ao_nxt;

  assign abus   = di_q;
  assign pc_nxt = (pc_from_bus ? abus : pc_q) + STEP;
  assign ao_nxt = ao_from_bus ? abus : pc_q;

  always_comb begin
    case (alu_op)
      3'b000:  alu_y = abus;
      3'b001:  alu_y = ~ac_q;
      3'b010:  alu_y = abus & ac_q;
      3'b011:  alu_y = abus + ac_q;
      3'b100:  alu_y = {1'b0, ac_q[W-1:1]};
      default: alu_y = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ac_q <= '0;
      pc_q <= '0;
      ao_q <= '0;
      di_q <= '0;
    end else begin
      if (ac_le) ac_q <= alu_y;
      if (pc_le) pc_q <= pc_nxt;
      if (ao_le) ao_q <= ao_nxt;
      if (di_le) di_q <= rd_data;
    end
  end

  assign addr_bus = ao_q;
  assign wr_data  = ac_q;
  assign wr_en    = dbus_sel;
  assign mem_cmd  = mem_op;
  assign opcode   = di_q[OPC_HI:OPC_LO];
  assign ac_sign  = ac_q[W-1];
endmodule

module acc_datapath_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [2:0]   alu_op,
  input logic         di_le,
  input logic         ac_le,
  input logic         ao_le,
  input logic [W-1:0] rd_data,
  input logic [W-1:0] addr_bus,
  input logic [W-1:0] wr_data,
  input logic [4:0]   opcode
);
  // R2
  opcode_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    di_le |=> opcode == $past(rd_data[W-2:W-6]));

  // R3
  invert_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ac_le && alu_op == 3'b001) |=> wr_data == ~$past(wr_data));

  // R4
  ac_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ac_le |=> $stable(wr_data));

  // R4
  unused_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ac_le && alu_op > 3'b100) |=> wr_data == '0);

  // R6
  ao_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ao_le |=> $stable(addr_bus));
endmodule

bind acc_datapath acc_datapath_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .alu_op(alu_op), .di_le(di_le), .ac_le(ac_le),
  .ao_le(ao_le), .rd_data(rd_data), .addr_bus(addr_bus), .wr_data(wr_data),
  .opcode(opcode)
);

// File: tb/acc_datapath_tb.sv
`timescale 1ns/1ps
module acc_datapath_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  alu_op = '0;
  logic        di_le = 0, ac_le = 0, pc_le = 0, pc_from_bus = 0;
  logic        ao_le = 0, ao_from_bus = 0, dbus_sel = 0;
  logic [1:0]  mem_op = '0;
  logic [15:0] rd_data = '0;
  logic [15:0] addr_bus, wr_data;
  logic        wr_en, ac_sign;
  logic [1:0]  mem_cmd;
  logic [4:0]  opcode;

  int checks = 0;
  int errors = 0;
  logic [15:0] m_ac = '0, m_pc = '0, m_ao = '0, m_di = '0;

  always #2 clk = ~clk;

  acc_datapath dut_i (.*);

  function automatic logic [15:0] alu_ref(input logic [2:0] op, input logic [15:0] a, input logic [15:0] b);
    case (op)
      3'd0: return a;
      3'd1: return ~b;
      3'd2: return a & b;
      3'd3: return a + b;
      3'd4: return b >> 1;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R6 addr_bus", addr_bus, m_ao);
    chk("R3 wr_data", wr_data, m_ac);
    chk("R2 opcode", {11'd0, opcode}, {11'd0, m_di[14:10]});
    chk("R8 ac_sign", {15'd0, ac_sign}, {15'd0, m_ac[15]});
    chk("R7 wr_en", {15'd0, wr_en}, {15'd0, dbus_sel});
    chk("R7 mem_cmd", {14'd0, mem_cmd}, {14'd0, mem_op});
  endtask

  task automatic step(input logic [2:0] op, input logic dle, input logic ale, input logic ple,
                      input logic psel, input logic ole, input logic osel, input logic [15:0] rd);
    logic [15:0] n_ac, n_pc, n_ao, n_di;
    alu_op = op; di_le = dle; ac_le = ale; pc_le = ple; pc_from_bus = psel;
    ao_le = ole; ao_from_bus = osel; rd_data = rd;
    dbus_sel = $urandom % 2; mem_op = 2'($urandom % 3);
    n_ac = ale ? alu_ref(op, m_di, m_ac) : m_ac;
    n_pc = ple ? ((psel ? m_di : m_pc) + 16'd2) : m_pc;
    n_ao = ole ? (osel ? m_di : m_pc) : m_ao;
    n_di = dle ? rd : m_di;
    @(posedge clk);
    m_ac = n_ac; m_pc = n_pc; m_ao = n_ao; m_di = n_di;
    @(negedge clk);
    check_all();
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4206));
    repeat (3) @(negedge clk);
    // R1 reset state
    check_all();
    chk("R1 addr_bus", addr_bus, 16'h0000);
    chk("R1 wr_data", wr_data, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);

    // R5 PC increments from reset: AO gets old PC then new PC
    step(3'd0, 0, 0, 1, 0, 1, 0, 16'h0);
    chk("R6 ao took pre-edge pc", addr_bus, 16'h0000);
    step(3'd0, 0, 0, 0, 0, 1, 0, 16'h0);
    chk("R5 pc plus two", addr_bus, 16'h0002);

    // R5 jump: load A-bus and add two; AO takes target
    step(3'd0, 1, 0, 0, 0, 0, 0, 16'h8C34);
    chk("R2 opcode field", {11'd0, opcode}, 16'h0003);
    step(3'd0, 0, 0, 1, 1, 1, 1, 16'h0);
    chk("R6 ao takes target", addr_bus, 16'h8C34);
    step(3'd0, 0, 0, 0, 0, 1, 0, 16'h0);
    chk("R5 pc target plus two", addr_bus, 16'h8C36);

    // R5 wrap
    step(3'd0, 1, 0, 0, 0, 0, 0, 16'hFFFE);
    step(3'd0, 0, 0, 1, 1, 0, 0, 16'h0);
    step(3'd0, 0, 0, 0, 0, 1, 0, 16'h0);
    chk("R5 pc wrap", addr_bus, 16'h0000);

    // R3 each ALU code on known operands
    step(3'd0, 1, 0, 0, 0, 0, 0, 16'h9003);
    step(3'd0, 0, 1, 0, 0, 0, 0, 16'h0);
    chk("R3 pass A", wr_data, 16'h9003);
    chk("R8 sign set", {15'd0, ac_sign}, 16'h0001);
    step(3'd4, 0, 1, 0, 0, 0, 0, 16'h0);
    chk("R3 halve B zero fill", wr_data, 16'h4801);
    step(3'd1, 0, 1, 0, 0, 0, 0, 16'h0);
    chk("R3 invert B", wr_data, 16'hB7FE);
    step(3'd2, 0, 1, 0, 0, 0, 0, 16'h0);
    chk("R3 and", wr_data, 16'h9002);
    step(3'd3, 0, 1, 0, 0, 0, 0, 16'h0);
    chk("R3 add carry out", wr_data, 16'h2005);
    // R4 enable low: AC unchanged under a destructive op
    step(3'd1, 0, 0, 0, 0, 0, 0, 16'h0);
    chk("R4 hold", wr_data, 16'h2005);
    for (int c = 5; c < 8; c++) begin
      step(3'd0, 0, 1, 0, 0, 0, 0, 16'h0);
      step(3'(c), 0, 1, 0, 0, 0, 0, 16'h0);
      chk("R4 unused code zero", wr_data, 16'h0000);
    end

    // random mix
    for (int i = 0; i < 400; i++) begin
      step(3'($urandom % 8), 1'($urandom), 1'($urandom), 1'($urandom),
           1'($urandom), 1'($urandom), 1'($urandom), 16'($urandom));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule